// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a 256-word, 16-bit serial EEPROM at the bit level. A host drives the memory by writing a small control register that carries three levels at once: chip select, serial clock and serial data in. Each register write is compared with the levels held from the previous write. Rising and falling edges of chip select and serial clock are found this way and advance the serial protocol. The single output is the serial data-out bit, which always shows the top bit of a 17-bit shift register.

A command starts with a start bit, which is a clock rising edge with data high while the slave is idle. A 2-bit opcode follows, then an 8-bit word address, all sent most significant bit first. Opcode 01 writes a word and opcode 10 reads one. Opcode 11 blanks a word to 0xFFFF. Opcode 00 is a group of special commands, chosen by the two top address bits. A rising chip select commits a pending write. Writes stay blocked until the host enables them, and they can be disabled again.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, writes are disabled, the sequencer is in its null state, doOut is 1 (the shift register is all ones) and every word reads 0xFFFF.
- R2: When a write cycle is pending, a rising chip select ends it. If writes are enabled, the low 16 shift-register bits are stored at the addressed word. The shift register is then set to all ones (doOut = 1) and the null state is entered. In any other state, a rising chip select enters idle.
- R3: In idle, a clock rising edge with DI = 1 is a start bit: it clears the shift register and the bit counter. A clock rising edge with DI = 0 in idle is ignored.
- R4: Opcode 00 is decoded by address bits [7:6]. Value 11 enables writes and value 00 disables them; both return to null.
- R5: Opcode 00 with address bits [7:6] = 01 takes 16 data bits (MSB first). If writes are enabled, every word is set to that value on the 16th bit.
- R6: Opcode 00 with address bits [7:6] = 10 takes 16 clocks. If writes are enabled, every word is then set to 0xFFFF and the shift register is loaded with 0xFFFF.
- R7: Opcode 01 shifts in 16 data bits, MSB first, and commits them to the addressed word on the next rising chip select.
- R8: Opcode 11 waits 16 clocks, loads 0xFFFF and commits it to the addressed word on the next rising chip select.
- R9: Opcode 10 reads. One more clock rising edge loads the addressed word, and doOut then shows a dummy 0. Each of the next 16 clock falling edges shifts the register left, so doOut presents the word MSB first. After the 16th falling edge the sequencer is in null and further clock edges leave doOut unchanged.
- R10: While writes are disabled, word writes, blanking, write-all and erase-all leave the storage unchanged.
- R11: A register write whose CS and SK levels equal the previous ones produces no edge, so repeating a level adds no extra bit. Without a register write the state does not change.
- R12: A rising chip select in the middle of a command or a read abandons it and enters idle without storing anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrite | input | 1 | One-cycle strobe that writes the control register |
| csIn | input | 1 | New chip-select level, taken when ctrlWrite is 1 |
| skIn | input | 1 | New serial-clock level, taken when ctrlWrite is 1 |
| diIn | input | 1 | New serial-data level, taken when ctrlWrite is 1 |
| doOut | output | 1 | Serial data out, bit 16 of the shift register |

## Verification
Each control-register write is taken at one rising clock edge. Every effect of that write shows up at the same edge, with no further latency: the edge-detect levels, the sequencer state, the shift register and so doOut, and the storage contents. The bench raises the write strobe at a falling edge, drops it at the next falling edge and samples doOut there, exactly one cycle after the stimulus. A storage update is observed only later, through a full read command driven across the serial pins, so no storage result is sampled before the read that shows it.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

  localparam int OP_W = 2;

  typedef enum logic [3:0] {
    ST_NULL,
    ST_IDLE,
    ST_OPCODE,
    ST_ADDRESS,
    ST_SPECIAL,
    ST_DATAIN,
    ST_FETCH,
    ST_BLANK,
    ST_COMMIT,
    ST_READOUT
  } seqState_t;

  typedef struct packed {
    logic setOnes;
    logic clrSr;
    logic clrBits;
    logic captureOp;
    logic captureAddr;
    logic loadBlank;
    logic loadWord;
    logic shiftOut;
    logic commitWord;
    logic fillAll;
    logic eraseAll;
  } dpStrobe_t;

endpackage

// File: rtl/ee3w_store.sv
module ee3w_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commitWord,
  input  logic              fillAll,
  input  logic              eraseAll,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] wordView [DEPTH];

  // Each word is kept as a high byte followed by a low byte.
  for (genvar gw = 0; gw < DEPTH; gw++) begin : g_word
    logic [BYTE_W-1:0] hiByte;
    logic [BYTE_W-1:0] loByte;
    logic              hitWord;

    assign hitWord = commitWord && (wordAddr == ADDR_W'(gw));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiByte <= '1;
        loByte <= '1;
      end else if (eraseAll) begin
        hiByte <= '1;
        loByte <= '1;
      end else if (fillAll || hitWord) begin
        hiByte <= wrData[DATA_W-1:BYTE_W];
        loByte <= wrData[BYTE_W-1:0];
      end
    end

    assign wordView[gw] = {hiByte, loByte};
  end

  assign rdData = wordView[wordAddr];

  assert_erase_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    eraseAll |=> (wordView[0] == '1) && (wordView[DEPTH-1] == '1));

  assert_fill_spread_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fillAll && !eraseAll) |=> (wordView[0] == wordView[DEPTH-1]));

endmodule

// File: rtl/ee3w_datapath.sv
module ee3w_datapath
  import ee3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              shiftIn,
  input  logic              diIn,
  input  logic [DATA_W-1:0] readWord,
  output logic [CNT_W-1:0]  bitCount,
  output logic [OP_W-1:0]   opCode,
  output logic [1:0]        incomingTop,
  output logic [1:0]        addrClass,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [DATA_W-1:0] storeData,
  output logic              doOut
);

  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] shiftReg;
  logic [SR_W-1:0] srShifted;
  logic [SR_W-1:0] srNext;
  logic [CNT_W-1:0] cntNext;

  assign srShifted   = {shiftReg[DATA_W-1:0], diIn};
  assign incomingTop = srShifted[ADDR_W-1 -: 2];
  assign addrClass   = wordAddr[ADDR_W-1 -: 2];
  assign storeData   = strb.fillAll ? srShifted[DATA_W-1:0] : shiftReg[DATA_W-1:0];
  assign doOut       = shiftReg[DATA_W];

  always_comb begin
    srNext = shiftReg;
    if (strb.setOnes)   srNext = '1;
    if (shiftIn)        srNext = srShifted;
    if (strb.shiftOut)  srNext = {shiftReg[DATA_W-1:0], 1'b0};
    if (strb.clrSr)     srNext = '0;
    if (strb.loadBlank) srNext = {1'b0, {DATA_W{1'b1}}};
    if (strb.loadWord)  srNext = {1'b0, readWord};
  end

  always_comb begin
    cntNext = bitCount;
    if (shiftIn || strb.shiftOut) cntNext = bitCount + CNT_W'(1);
    if (strb.clrBits)             cntNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitCount <= '0;
      opCode   <= '0;
      wordAddr <= '0;
    end else begin
      shiftReg <= srNext;
      bitCount <= cntNext;
      if (strb.captureOp)   opCode   <= srShifted[OP_W-1:0];
      if (strb.captureAddr) wordAddr <= srShifted[ADDR_W-1:0];
    end
  end

  assert_fetch_dummy_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> !doOut);

  assert_blank_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBlank |=> (!doOut && shiftReg[DATA_W-1:0] == '1));

  assert_end_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setOnes && !strb.clrSr) |=> doOut);

  assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrSr |=> (shiftReg == '0 && bitCount == '0));

endmodule

// File: rtl/ee3w_seq_ctrl.sv
module ee3w_seq_ctrl
  import ee3w_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrite,
  input  logic             csIn,
  input  logic             skIn,
  input  logic             diIn,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [OP_W-1:0]  opCode,
  input  logic [1:0]       incomingTop,
  input  logic [1:0]       addrClass,
  output logic             shiftIn,
  output dpStrobe_t        strb
);

  localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(8 - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FIRST_BIT = '0;

  seqState_t state, stateMid, stateNext;
  logic      csPrev, skPrev;
  logic      writable, writableNext;
  logic      csRise, skRise, skFall;

  assign csRise = ctrlWrite && csIn && !csPrev;
  assign skRise = ctrlWrite && skIn && !skPrev;
  assign skFall = ctrlWrite && !skIn && skPrev;

  // Chip-select edge resolves first; the clock edge acts on its result.
  always_comb begin
    stateMid = state;
    if (csRise) stateMid = (state == ST_COMMIT) ? ST_NULL : ST_IDLE;
  end

  always_comb begin
    shiftIn = skRise && (stateMid inside {ST_OPCODE, ST_ADDRESS, ST_SPECIAL,
                                          ST_DATAIN, ST_FETCH, ST_BLANK, ST_COMMIT});
  end

  always_comb begin
    strb         = '0;
    stateNext    = stateMid;
    writableNext = writable;

    if (csRise && state == ST_COMMIT) begin
      strb.commitWord = writable;
      strb.setOnes    = 1'b1;
    end

    if (skRise) begin
      unique case (stateMid)
        ST_IDLE: begin
          if (diIn) begin
            strb.clrSr   = 1'b1;
            strb.clrBits = 1'b1;
            stateNext    = ST_OPCODE;
          end
        end
        ST_OPCODE: begin
          if (bitCount == LAST_OP) begin
            strb.captureOp = 1'b1;
            strb.clrBits   = 1'b1;
            stateNext      = ST_ADDRESS;
          end
        end
        ST_ADDRESS: begin
          if (bitCount == LAST_ADDR) begin
            strb.captureAddr = 1'b1;
            strb.clrBits     = 1'b1;
            unique case (opCode)
              2'b01: stateNext = ST_DATAIN;
              2'b10: stateNext = ST_FETCH;
              2'b11: stateNext = ST_BLANK;
              default: begin
                unique case (incomingTop)
                  2'b00: begin
                    writableNext = 1'b0;
                    stateNext    = ST_NULL;
                  end
                  2'b11: begin
                    writableNext = 1'b1;
                    stateNext    = ST_NULL;
                  end
                  default: stateNext = ST_SPECIAL;
                endcase
              end
            endcase
          end
        end
        ST_SPECIAL: begin
          if (bitCount == LAST_DATA) begin
            strb.clrBits = 1'b1;
            unique case (addrClass)
              2'b01: begin
                strb.fillAll = writable;
                stateNext    = ST_COMMIT;
              end
              2'b10: begin
                strb.eraseAll  = writable;
                strb.loadBlank = 1'b1;
                stateNext      = ST_COMMIT;
              end
              default: stateNext = ST_NULL;
            endcase
          end
        end
        ST_DATAIN: begin
          if (bitCount == LAST_DATA) begin
            strb.clrBits = 1'b1;
            stateNext    = ST_COMMIT;
          end
        end
        ST_FETCH: begin
          if (bitCount == FIRST_BIT) begin
            strb.loadWord = 1'b1;
            strb.clrBits  = 1'b1;
            stateNext     = ST_READOUT;
          end
        end
        ST_BLANK: begin
          if (bitCount == LAST_DATA) begin
            strb.loadBlank = 1'b1;
            strb.clrBits   = 1'b1;
            stateNext      = ST_COMMIT;
          end
        end
        default: ;
      endcase
    end else if (skFall && stateMid == ST_READOUT) begin
      strb.shiftOut = 1'b1;
      if (bitCount == LAST_DATA) begin
        strb.clrBits = 1'b1;
        stateNext    = ST_NULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_NULL;
      csPrev   <= 1'b0;
      skPrev   <= 1'b0;
      writable <= 1'b0;
    end else begin
      state    <= stateNext;
      writable <= writableNext;
      if (ctrlWrite) begin
        csPrev <= csIn;
        skPrev <= skIn;
      end
    end
  end

  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> ($stable(state) && $stable(writable)));

  assert_readout_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READOUT) |-> (bitCount < CNT_W'(DATA_W)));

  assert_bulk_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillAll || strb.eraseAll) |=> (state == ST_COMMIT));

  assert_cs_abort_R12: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && state != ST_COMMIT && !skRise) |=> (state == ST_IDLE));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import ee3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctrlWrite,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  dpStrobe_t         strb;
  logic              shiftIn;
  logic [CNT_W-1:0]  bitCount;
  logic [OP_W-1:0]   opCode;
  logic [1:0]        incomingTop;
  logic [1:0]        addrClass;
  logic [ADDR_W-1:0] wordAddr;
  logic [DATA_W-1:0] storeData;
  logic [DATA_W-1:0] readWord;

  ee3w_seq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .csIn(csIn), .skIn(skIn),
    .diIn(diIn), .bitCount(bitCount), .opCode(opCode), .incomingTop(incomingTop),
    .addrClass(addrClass), .shiftIn(shiftIn), .strb(strb)
  );

  ee3w_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shiftIn(shiftIn), .diIn(diIn),
    .readWord(readWord), .bitCount(bitCount), .opCode(opCode),
    .incomingTop(incomingTop), .addrClass(addrClass), .wordAddr(wordAddr),
    .storeData(storeData), .doOut(doOut)
  );

  ee3w_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rstN(rstN), .commitWord(strb.commitWord), .fillAll(strb.fillAll),
    .eraseAll(strb.eraseAll), .wordAddr(wordAddr), .wrData(storeData),
    .rdData(readWord)
  );

endmodule

// File: tb/test_serial_eeprom_slave.sv
`timescale 1ns/1ps
module test_serial_eeprom_slave;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrite = 1'b0;
  logic csIn = 1'b0, skIn = 1'b0, diIn = 1'b0;
  logic doOut;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [256];
  bit modelWen = 1'b0;

  always #2.5 clk = ~clk;

  serial_eeprom_slave i_serial_eeprom_slave (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .csIn(csIn), .skIn(skIn),
    .diIn(diIn), .doOut(doOut)
  );

  function automatic logic [15:0] expectWord(input logic [7:0] a);
    return model[a];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pinWrite(input logic cs, input logic sk, input logic di);
    @(negedge clk);
    csIn = cs; skIn = sk; diIn = di; ctrlWrite = 1'b1;
    @(negedge clk);
    ctrlWrite = 1'b0;
  endtask

  task automatic bitRise(input logic di);
    pinWrite(1'b1, 1'b0, di);
    pinWrite(1'b1, 1'b1, di);
  endtask

  task automatic selectChip();
    pinWrite(1'b0, 1'b0, 1'b0);
    pinWrite(1'b1, 1'b0, 1'b0);
  endtask

  task automatic sendBody(input logic [1:0] op, input logic [7:0] a);
    bitRise(1'b1);
    bitRise(op[1]);
    bitRise(op[0]);
    for (int i = 7; i >= 0; i--) bitRise(a[i]);
  endtask

  task automatic sendCommand(input logic [1:0] op, input logic [7:0] a);
    selectChip();
    sendBody(op, a);
  endtask

  task automatic shiftData(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) bitRise(d[i]);
  endtask

  task automatic endCycle();
    pinWrite(1'b0, 1'b0, 1'b0);
    pinWrite(1'b1, 1'b0, 1'b0);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    sendCommand(2'b01, a);
    shiftData(d);
    endCycle();
    if (modelWen) model[a] = d;
  endtask

  task automatic doBlank(input logic [7:0] a);
    sendCommand(2'b11, a);
    shiftData(16'($urandom));
    endCycle();
    if (modelWen) model[a] = 16'hFFFF;
  endtask

  task automatic doEnable();
    sendCommand(2'b00, {2'b11, 6'($urandom)});
    modelWen = 1'b1;
  endtask

  task automatic doDisable();
    sendCommand(2'b00, {2'b00, 6'($urandom)});
    modelWen = 1'b0;
  endtask

  task automatic doWriteAll(input logic [15:0] d);
    sendCommand(2'b00, {2'b01, 6'($urandom)});
    shiftData(d);
    endCycle();
    if (modelWen) for (int i = 0; i < 256; i++) model[i] = d;
  endtask

  task automatic doEraseAll();
    sendCommand(2'b00, {2'b10, 6'($urandom)});
    shiftData(16'($urandom));
    endCycle();
    if (modelWen) for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
  endtask

  task automatic readBody(input logic [7:0] a, output logic [15:0] v, output logic dummy);
    sendBody(2'b10, a);
    bitRise(1'b0);
    dummy = doOut;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      pinWrite(1'b1, 1'b0, 1'b0);
      v = {v[14:0], doOut};
      if (i < 15) pinWrite(1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic checkRead(input logic [7:0] a, input string req);
    logic [15:0] v;
    logic dummy;
    selectChip();
    readBody(a, v, dummy);
    check(v == expectWord(a), req, $sformatf("read word %0d", a), 32'(v), 32'(expectWord(a)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic dummy;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(doOut == 1'b1, "R1", "doOut after reset", 32'(doOut), 32'd1);
    selectChip();
    readBody(8'd0, v, dummy);
    check(v == 16'hFFFF, "R1", "word 0 after reset", 32'(v), 32'hFFFF);
    selectChip();
    readBody(8'd255, v, dummy);
    check(v == 16'hFFFF, "R1", "word 255 after reset", 32'(v), 32'hFFFF);
    check(dummy == 1'b0, "R9", "dummy bit before data", 32'(dummy), 32'd0);

    // R10: writes disabled after reset
    doWrite(8'd5, 16'h1234);
    checkRead(8'd5, "R10");

    // R3: DI low edges in idle are not start bits
    selectChip();
    bitRise(1'b0);
    bitRise(1'b0);
    readBody(8'd5, v, dummy);
    check(v == 16'hFFFF, "R3", "read after idle zero clocks", 32'(v), 32'hFFFF);

    // R4, R7, R2: enable then write and commit
    doEnable();
    sendCommand(2'b01, 8'd5);
    shiftData(16'hA55A);
    endCycle();
    model[5] = 16'hA55A;
    check(doOut == 1'b1, "R2", "doOut after commit", 32'(doOut), 32'd1);
    checkRead(8'd5, "R7");
    checkRead(8'd5, "R4");

    // R11: repeated levels add no bits
    selectChip();
    sendBody(2'b01, 8'd9);
    for (int i = 15; i >= 0; i--) begin
      logic b;
      b = 1'(16'h0F0F >> i);
      pinWrite(1'b1, 1'b0, b);
      pinWrite(1'b1, 1'b0, b);
      pinWrite(1'b1, 1'b1, b);
      pinWrite(1'b1, 1'b1, b);
    end
    endCycle();
    model[9] = 16'h0F0F;
    checkRead(8'd9, "R11");

    // R12: abort a write mid-data
    sendCommand(2'b01, 8'd9);
    for (int i = 0; i < 8; i++) bitRise(1'b0);
    pinWrite(1'b0, 1'b1, 1'b1);
    pinWrite(1'b1, 1'b1, 1'b1);
    checkRead(8'd9, "R12");

    // R12: abort a read, then a new command from idle
    sendCommand(2'b10, 8'd5);
    bitRise(1'b0);
    for (int i = 0; i < 3; i++) begin
      pinWrite(1'b1, 1'b0, 1'b0);
      pinWrite(1'b1, 1'b1, 1'b0);
    end
    pinWrite(1'b0, 1'b1, 1'b0);
    pinWrite(1'b1, 1'b1, 1'b0);
    readBody(8'd9, v, dummy);
    check(v == 16'h0F0F, "R12", "read after aborted read", 32'(v), 32'h0F0F);

    // R8: blank a word
    doBlank(8'd5);
    checkRead(8'd5, "R8");

    // R5: write-all
    doWriteAll(16'h3C3C);
    checkRead(8'd0, "R5");
    checkRead(8'd255, "R5");
    checkRead(8'd77, "R5");

    // R10: disabled erase-all and write have no effect
    doDisable();
    doEraseAll();
    doWrite(8'd100, 16'h0001);
    checkRead(8'd100, "R10");
    checkRead(8'd3, "R10");

    // R6: erase-all
    doEnable();
    doEraseAll();
    checkRead(8'd0, "R6");
    checkRead(8'd200, "R6");

    // R9: read tail, doOut holds after the 16th shift
    doWrite(8'd3, 16'h8001);
    selectChip();
    readBody(8'd3, v, dummy);
    check(v == 16'h8001, "R9", "read word 3", 32'(v), 32'h8001);
    check(dummy == 1'b0, "R9", "dummy bit", 32'(dummy), 32'd0);
    pinWrite(1'b1, 1'b1, 1'b0);
    pinWrite(1'b1, 1'b0, 1'b0);
    pinWrite(1'b1, 1'b1, 1'b0);
    pinWrite(1'b1, 1'b0, 1'b0);
    check(doOut == 1'b1, "R9", "doOut held after read end", 32'(doOut), 32'd1);

    // Random mix
    for (int it = 0; it < 70; it++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 255));
      case ($urandom_range(0, 11))
        0, 1, 2: doWrite(a, 16'($urandom));
        3:       doBlank(a);
        4, 5:    doEnable();
        6:       doDisable();
        7, 8, 9, 10: checkRead(a, "R7");
        default: if ($urandom_range(0, 1) == 0) doWriteAll(16'($urandom)); else doEraseAll();
      endcase
    end
    for (int i = 0; i < 8; i++) checkRead(8'($urandom_range(0, 255)), "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule